// File: doc/BRIEF.md
# Virtio Memory Window Decoder

This block sits behind one memory base-address window of a paravirtual device function. It splits the window into four fixed parts. The shared configuration registers and the device-specific registers live outside the block, and their accesses are forwarded to two side ports. The interrupt status register is held inside the block. A write anywhere in the doorbell area becomes a one-cycle notify pulse that carries the queue number.

An access is one cycle wide: `req` high, with `req_wr`, `req_addr`, `req_size` and `req_wdata`. A read returns its data one cycle later on `rsp_rdata`, together with `rsp_valid`. Data is little endian and right-justified: the lowest-addressed byte travels in bits 7:0. The side ports are combinational in the request cycle and must answer on their read-data inputs within that same cycle.

Top module: `qbar_router`

## Requirements
- R1: After reset, `rsp_valid`, `ntf_valid` and `irq` are 0, and the status register reads 0.
- R2: An access at offset 0x0000..0x0FFF drives `cmn_req` with `cmn_off` = the address bits 11:0. An access at 0x2000..0x2FFF does the same on the `dev_*` port. In both cases the write flag and the size code are passed through unchanged, and the write data is masked to its size.
- R3: A read raises `rsp_valid` for exactly one cycle, in the cycle after the request. The read data is masked to the size code: 0 keeps 1 byte (bits 7:0), 1 keeps 2 bytes (bits 15:0), and 2 or 3 keep 4 bytes.
- R4: A write at an address A with 0x3000 <= A < 0x3000 + MAX_Q*0x10000 raises `ntf_valid` for one cycle, in the next cycle, with `ntf_queue` = (A - 0x3000) >> 16.
- R5: A read in the doorbell area returns 0 and raises no notify.
- R6: A pulse on `q_irq_evt` sets status bit 0, and a pulse on `cfg_irq_evt` sets status bit 1. `irq` is high whenever the status value is non-zero.
- R7: A read at 0x1000..0x1FFF returns the status value held before the read, then clears it to 0, which drops `irq`.
- R8: An event arriving in the same cycle as a clearing read still sets its bit, and that read returns the old value.
- R9: A write at 0x1000..0x1FFF leaves the status value unchanged.
- R10: Any other address, including the doorbell area at or past MAX_Q queues, reads 0, forwards nothing and notifies nothing.
- R11: `cmn_req` and `dev_req` are never high together, and neither one is high without `req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access strobe, one cycle per access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, masked to the size |
| cmn_req | output | 1 | Shared-configuration access strobe |
| cmn_wr | output | 1 | Shared-configuration write flag |
| cmn_off | output | 12 | Shared-configuration offset |
| cmn_size | output | 2 | Shared-configuration size code |
| cmn_wdata | output | 32 | Shared-configuration write data |
| cmn_rdata | input | 32 | Shared-configuration read data, same cycle |
| dev_req | output | 1 | Device-configuration access strobe |
| dev_wr | output | 1 | Device-configuration write flag |
| dev_off | output | 12 | Device-configuration offset |
| dev_size | output | 2 | Device-configuration size code |
| dev_wdata | output | 32 | Device-configuration write data |
| dev_rdata | input | 32 | Device-configuration read data, same cycle |
| q_irq_evt | input | 1 | Queue interrupt event pulse |
| cfg_irq_evt | input | 1 | Configuration-change event pulse |
| irq | output | 1 | Level interrupt line |
| ntf_valid | output | 1 | Queue notify pulse |
| ntf_queue | output | QW | Notified queue index |

## Verification
Errors inside the block show up at the ports within one cycle of the access that exposes them. A wrong region decode moves a strobe onto the wrong side port in the request cycle itself, or puts non-zero data where zero is expected. A wrong status value is exposed by the next status read, and also through `irq` one cycle after the event or the clear. A wrong shift in the queue index appears on `ntf_queue` in the cycle after the doorbell write. Because of this, the bench checks the side ports in the request cycle and all registered outputs in the following cycle.

// File: rtl/qbar_pkg.sv
package qbar_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_COMMON,
    RG_ISR,
    RG_DEVICE,
    RG_DOORBELL
  } region_e;

  localparam logic [31:0] ISR_BASE    = 32'h0000_1000;
  localparam logic [31:0] DEV_BASE    = 32'h0000_2000;
  localparam logic [31:0] BELL_BASE   = 32'h0000_3000;
  localparam int unsigned BELL_SHIFT  = 16;

  // Region selection from a zero-extended offset.
  function automatic region_e region_of(input logic [31:0] a, input int unsigned max_q);
    if (a < ISR_BASE)       return RG_COMMON;
    else if (a < DEV_BASE)  return RG_ISR;
    else if (a < BELL_BASE) return RG_DEVICE;
    else if (((a - BELL_BASE) >> BELL_SHIFT) < max_q) return RG_DOORBELL;
    else return RG_NONE;
  endfunction

  // Queue number addressed by a doorbell offset.
  function automatic logic [31:0] bell_queue(input logic [31:0] a);
    return (a - BELL_BASE) >> BELL_SHIFT;
  endfunction

  // Byte-lane mask for a size code.
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/qbar_decode.sv
module qbar_decode
  import qbar_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned MAX_Q  = 4,
  localparam int unsigned QW    = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rg,
  output logic [QW-1:0]     qidx
);
  logic [31:0] addr32;
  assign addr32 = 32'(addr);
  assign rg     = region_of(addr32, MAX_Q);
  assign qidx   = QW'(bell_queue(addr32));
endmodule

// File: rtl/qbar_isr.sv
module qbar_isr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_evt,
  input  logic       cfg_evt,
  input  logic       rd_clr,
  output logic [1:0] isr,
  output logic       irq
);
  logic [1:0] set_bits;
  assign set_bits = {cfg_evt, q_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr <= 2'b00;
    else if (rd_clr) isr <= set_bits;          // new events survive the clear
    else             isr <= isr | set_bits;
  end

  assign irq = |isr;

  a_r6_queue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    q_evt |=> isr[0] && irq);
  a_r6_cfg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt |=> isr[1] && irq);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !q_evt && !cfg_evt) |=> (isr == 2'b00) && !irq);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (q_evt || cfg_evt)) |=> irq);
endmodule

// File: rtl/qbar_doorbell.sv
module qbar_doorbell #(
  parameter int unsigned QW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [QW-1:0] qin,
  output logic          ntf_valid,
  output logic [QW-1:0] ntf_queue
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_valid <= 1'b0;
      ntf_queue <= '0;
    end else begin
      ntf_valid <= fire;
      if (fire) ntf_queue <= qin;
    end
  end

  a_r4_notify_next: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ntf_valid && (ntf_queue == $past(qin)));
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !ntf_valid);
endmodule

// File: rtl/qbar_router.sv
module qbar_router
  import qbar_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned MAX_Q  = 4,
  localparam int unsigned QW    = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              cmn_req,
  output logic              cmn_wr,
  output logic [11:0]       cmn_off,
  output logic [1:0]        cmn_size,
  output logic [31:0]       cmn_wdata,
  input  logic [31:0]       cmn_rdata,
  output logic              dev_req,
  output logic              dev_wr,
  output logic [11:0]       dev_off,
  output logic [1:0]        dev_size,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata,
  input  logic              q_irq_evt,
  input  logic              cfg_irq_evt,
  output logic              irq,
  output logic              ntf_valid,
  output logic [QW-1:0]     ntf_queue
);
  region_e     rg;
  logic [QW-1:0] qidx;
  logic [1:0]  isr_val;
  logic [31:0] lane_mask;
  logic [31:0] wdata_m;
  logic [31:0] rd_sel;
  logic        rd_hit;
  logic        isr_rd_clr;
  logic        bell_fire;

  qbar_decode #(.ADDR_W(ADDR_W), .MAX_Q(MAX_Q)) u_dec (
    .addr (req_addr),
    .rg   (rg),
    .qidx (qidx)
  );

  assign lane_mask  = size_mask(req_size);
  assign wdata_m    = req_wdata & lane_mask;
  assign rd_hit     = req && !req_wr;
  assign isr_rd_clr = rd_hit && (rg == RG_ISR);
  assign bell_fire  = req && req_wr && (rg == RG_DOORBELL);

  // Forwarded side ports.
  assign cmn_req   = req && (rg == RG_COMMON);
  assign cmn_wr    = req_wr;
  assign cmn_off   = req_addr[11:0];
  assign cmn_size  = req_size;
  assign cmn_wdata = wdata_m;
  assign dev_req   = req && (rg == RG_DEVICE);
  assign dev_wr    = req_wr;
  assign dev_off   = req_addr[11:0];
  assign dev_size  = req_size;
  assign dev_wdata = wdata_m;

  qbar_isr u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_evt   (q_irq_evt),
    .cfg_evt (cfg_irq_evt),
    .rd_clr  (isr_rd_clr),
    .isr     (isr_val),
    .irq     (irq)
  );

  qbar_doorbell #(.QW(QW)) u_bell (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (bell_fire),
    .qin       (qidx),
    .ntf_valid (ntf_valid),
    .ntf_queue (ntf_queue)
  );

  always_comb begin
    case (rg)
      RG_COMMON: rd_sel = cmn_rdata;
      RG_ISR:    rd_sel = {30'b0, isr_val};
      RG_DEVICE: rd_sel = dev_rdata;
      default:   rd_sel = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'b0;
    end else begin
      rsp_valid <= rd_hit;
      rsp_rdata <= rd_hit ? (rd_sel & lane_mask) : 32'b0;
    end
  end

  a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmn_req, dev_req}) && ((cmn_req || dev_req) -> req));
  a_r3_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rsp_valid);
  a_r5_bell_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rg == RG_DOORBELL) |=> (rsp_rdata == 32'b0) && !ntf_valid);
  a_r10_none_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && rg == RG_NONE) |=> (rsp_rdata == 32'b0) && !ntf_valid);
  a_r9_isr_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_wr && rg == RG_ISR && !q_irq_evt && !cfg_irq_evt) |=> $stable(isr_val));
endmodule

// File: tb/qbar_router_tb.sv
module qbar_router_tb;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned MAX_Q  = 4;
  localparam int unsigned QW     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req = 0, req_wr = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              cmn_req, cmn_wr, dev_req, dev_wr;
  logic [11:0]       cmn_off, dev_off;
  logic [1:0]        cmn_size, dev_size;
  logic [31:0]       cmn_wdata, dev_wdata, cmn_rdata, dev_rdata;
  logic              q_irq_evt = 0, cfg_irq_evt = 0, irq, ntf_valid;
  logic [QW-1:0]     ntf_queue;

  assign cmn_rdata = {20'hC0DE5, cmn_off};
  assign dev_rdata = {20'hDEF1A, dev_off};

  qbar_router #(.ADDR_W(ADDR_W), .MAX_Q(MAX_Q)) u_dut (.*);

  int n_run = 0, n_fail = 0;
  logic [1:0] isr_m = 2'b00;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [1:0] s);
    if (s >= 2) return 32'hFFFFFFFF;
    return (32'h1 << (8 << s)) - 1;
  endfunction

  // kind: 0 none, 1 common, 2 status, 3 device, 4 doorbell
  function automatic int kind_of(input logic [ADDR_W-1:0] a);
    int unsigned v = a;
    if (v <= 32'h0FFF) return 1;
    if (v <= 32'h1FFF) return 2;
    if (v <= 32'h2FFF) return 3;
    if (v >= 32'h3000 && v < 32'h3000 + MAX_Q * 65536) return 4;
    return 0;
  endfunction

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit eq, input bit ec);
    int k = kind_of(a);
    logic [31:0] m = mask_of(sz);
    logic [31:0] exp_rd;
    logic [1:0] isr_next;
    @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_size = sz; req_wdata = wd;
    q_irq_evt = eq; cfg_irq_evt = ec;
    #1;
    chk(cmn_req == (k == 1), "R2 cmn_req", 32'(cmn_req), 32'(k == 1));
    chk(dev_req == (k == 3), "R2 dev_req", 32'(dev_req), 32'(k == 3));
    chk(!(cmn_req && dev_req), "R11 exclusive", {cmn_req, dev_req}, 0);
    if (k == 1) chk(cmn_off == a[11:0] && cmn_wr == wr && cmn_size == sz && cmn_wdata == (wd & m),
                    "R2 cmn fields", cmn_wdata, wd & m);
    if (k == 3) chk(dev_off == a[11:0] && dev_wr == wr && dev_size == sz && dev_wdata == (wd & m),
                    "R2 dev fields", dev_wdata, wd & m);
    case (k)
      1: exp_rd = {20'hC0DE5, a[11:0]} & m;
      2: exp_rd = {30'b0, isr_m} & m;
      3: exp_rd = {20'hDEF1A, a[11:0]} & m;
      default: exp_rd = 0;
    endcase
    isr_next = ((k == 2 && !wr) ? 2'b00 : isr_m) | {ec, eq};
    @(negedge clk);
    req = 0; q_irq_evt = 0; cfg_irq_evt = 0;
    chk(rsp_valid == !wr, "R3 rsp_valid", 32'(rsp_valid), 32'(!wr));
    if (!wr) begin
      if (k == 4)      chk(rsp_rdata == 0, "R5 doorbell read", rsp_rdata, 0);
      else if (k == 0) chk(rsp_rdata == 0, "R10 outside read", rsp_rdata, 0);
      else if (k == 2) chk(rsp_rdata == exp_rd, "R7 status read", rsp_rdata, exp_rd);
      else             chk(rsp_rdata == exp_rd, "R3 read data", rsp_rdata, exp_rd);
    end
    if (wr && k == 4) chk(ntf_valid && ntf_queue == QW'((32'(a) - 32'h3000) / 65536),
                          "R4 notify", {ntf_valid, 30'(ntf_queue)}, (32'(a) - 32'h3000) / 65536);
    else chk(!ntf_valid, "R10 no notify", 32'(ntf_valid), 0);
    isr_m = isr_next;
    chk(irq == (isr_m != 0), "R6 irq level", 32'(irq), 32'(isr_m != 0));
    @(negedge clk);
    chk(!rsp_valid, "R3 single pulse", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !ntf_valid && !irq, "R1 reset outputs", {rsp_valid, ntf_valid, irq}, 0);
    rst_n = 1;
    access(0, 20'h00000 + 20'h1000, 2, 0, 0, 0); // R1: status reads 0
    access(0, 20'h00004, 2, 0, 0, 0);             // R2 R3 common word
    access(0, 20'h00FFF, 0, 0, 0, 0);             // R3 byte mask
    access(0, 20'h02ABC, 1, 0, 0, 0);             // R3 half mask, device
    access(1, 20'h02010, 1, 32'h12345678, 0, 0);  // R2 device write
    access(1, 20'h03000, 2, 32'h1, 0, 0);         // R4 queue 0
    access(1, 20'h33020, 0, 32'h1, 0, 0);         // R4 queue 3
    access(1, 20'h43000, 2, 32'h1, 0, 0);         // R10 past last queue
    access(0, 20'h13000, 2, 0, 0, 0);             // R5 doorbell read
    access(0, 20'hFFFFF, 2, 0, 0, 0);             // R10 outside
    access(1, 20'h00100, 2, 0, 1, 0);             // R6 queue event
    access(0, 20'h01000, 2, 0, 0, 0);             // R7 read clears
    access(1, 20'h01000, 2, 32'hFFFFFFFF, 0, 1);  // R6 cfg event, R9 write ignored
    access(1, 20'h01004, 2, 32'h0, 0, 0);         // R9 write ignored
    access(0, 20'h01000, 2, 0, 0, 0);             // R9 value still 2
    access(1, 20'h00000, 2, 0, 0, 1);
    access(0, 20'h01000, 2, 0, 1, 0);             // R8 set wins
    access(0, 20'h01000, 2, 0, 0, 0);             // R8 event kept
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      case ($urandom % 6)
        0: a = ADDR_W'($urandom % 32'h1000);
        1: a = ADDR_W'(32'h1000 + $urandom % 32'h1000);
        2: a = ADDR_W'(32'h2000 + $urandom % 32'h1000);
        3: a = ADDR_W'(32'h3000 + $urandom % (MAX_Q * 65536));
        4: a = ADDR_W'(32'h43000 + $urandom % 32'hBD000);
        default: a = ADDR_W'($urandom);
      endcase
      access(1'($urandom), a, 2'($urandom), $urandom, 1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule